// File: doc/BRIEF.md
# Dual-Branch Clock Enable Divider Tree

This block produces the digital clock enables that sit around a frequency multiplier that serves a USB-capable system. On the oscillator clock, a prescaler divides by a ratio picked with a 3-bit code and emits a reference strobe. The intended setting is the one that brings the reference to 4 MHz. The block never measures the incoming frequency, so only the static code decides the ratio.

A second section runs on the fast multiplied clock, which is taken as an input (nominally 96 MHz, 24 times the reference). This section feeds two branches:
- The USB branch halves the fast clock. It gives a strobe and a 50%-duty divided clock at 48 MHz for as long as the USB enable is high.
- The system branch divides the fast clock by three (32 MHz). A postscaler then divides that result by 1, 2, 4 or 8, as picked by a 2-bit code.

Every output strobe lasts one cycle in its own clock domain. Each divider loads a new ratio only when it wraps.

Top module: `clk_branch_gen`

## Requirements
- R1: The prescaler code sets the period of `ref_stb` in `osc_clk` cycles as follows: 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→10, 7→12.
- R2: With a ratio N greater than 1, each `ref_stb` pulse is one cycle wide, so a 120-cycle window holds exactly 120/N pulses. With N = 1 the strobe stays high on every cycle.
- R3: While `osc_rst` is high, `ref_stb` is low. The first `ref_stb` is seen after the N-th rising `osc_clk` edge that follows the release of reset.
- R4: A change of `pre_sel` does not cut short the period in progress. The new ratio takes effect only once the prescaler next wraps.
- R5: While `usb_on` is high, `usb_clk` toggles on every `fast_clk` edge. `usb_stb` pulses on every second cycle and is high only while `usb_clk` is low. After reset, the first `usb_stb` is seen after the 2nd edge.
- R6: One edge after `usb_on` goes low, both `usb_stb` and `usb_clk` are low, and they stay low. On re-enable, `usb_clk` is high after the first edge and `usb_stb` after the second.
- R7: The period of `sys_stb` in `fast_clk` cycles is 3·2^k, where k is the value of `sys_sel` (0→3, 1→6, 2→12, 3→24). Each pulse is one cycle wide.
- R8: A change of `sys_sel` takes effect only once the postscaler next wraps. The period in progress finishes at the old ratio.
- R9: While `fast_rst` is high, `sys_stb`, `usb_stb` and `usb_clk` are low. The first `sys_stb` is seen after rising edge 3·2^k + 1 that follows the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |
| pre_sel | input | 3 | Prescaler ratio code |
| ref_stb | output | 1 | Reference strobe, oscillator domain |
| fast_clk | input | 1 | Fast multiplied clock |
| fast_rst | input | 1 | Synchronous active-high reset, fast domain |
| usb_on | input | 1 | USB branch enable |
| sys_sel | input | 2 | System postscaler code |
| usb_stb | output | 1 | USB branch strobe, fast domain |
| usb_clk | output | 1 | 50%-duty USB divided clock |
| sys_stb | output | 1 | System branch strobe, fast domain |

## Verification
A counter or a stored ratio with a wrong value moves a strobe edge, so the fault shows at the ports within a single divide period.
- An off-by-one count shifts the first strobe after reset, which is visible after N edges.
- A ratio register that is loaded at the wrong moment cuts short or stretches the period right after a code change.
- A bad phase in the USB half-divider makes `usb_stb` coincide with a high `usb_clk` on the very next strobe.

// File: rtl/clkbr_pkg.sv
package clkbr_pkg;
    localparam int PRE_SEL_W  = 3;
    localparam int PRE_CNT_W  = 4;
    localparam int POST_SEL_W = 2;
    localparam int USB_RATIO  = 2;
    localparam int SYS_RATIO  = 3;

    // prescaler ratio for each select code
    function automatic int unsigned pre_ratio(input logic [PRE_SEL_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 5;
            3'd5:    return 6;
            3'd6:    return 10;
            default: return 12;
        endcase
    endfunction
endpackage

// File: rtl/clkbr_div.sv
// Counter that wraps at a stored limit; the limit reloads only on wrap.
module clkbr_div #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ce,
    input  logic [CNT_W-1:0] lim_in,
    output logic             stb
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             stb;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (rst || clr) begin
            st_d.cnt = '0;
            st_d.lim = lim_in;
        end else if (ce) begin
            if (st_q.cnt == st_q.lim) begin
                st_d.cnt = '0;
                st_d.lim = lim_in;
                st_d.stb = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stb = st_q.stb;
endmodule

// File: rtl/clkbr_half.sv
// 50%-duty divided clock for an even ratio.
module clkbr_half #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic clk_out
);
    localparam int HALF = DIV / 2;
    localparam int HW   = $clog2(HALF + 1);

    typedef struct packed {
        logic [HW-1:0] hcnt;
        logic          level;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst || clr) begin
            st_d.hcnt  = '0;
            st_d.level = 1'b0;
        end else if (st_q.hcnt == HW'(HALF - 1)) begin
            st_d.hcnt  = '0;
            st_d.level = ~st_q.level;
        end else begin
            st_d.hcnt = st_q.hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign clk_out = st_q.level;
endmodule

// File: rtl/clkbr_pre.sv
// Oscillator-domain prescaler driven by a ratio code.
module clkbr_pre #(
    parameter int SEL_W = clkbr_pkg::PRE_SEL_W,
    parameter int CNT_W = clkbr_pkg::PRE_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             stb
);
    logic [CNT_W-1:0] lim_d;

    always_comb begin
        lim_d = CNT_W'(clkbr_pkg::pre_ratio(sel) - 1);
    end

    clkbr_div #(.CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (1'b0),
        .ce     (1'b1),
        .lim_in (lim_d),
        .stb    (stb)
    );
endmodule

// File: rtl/clkbr_fast.sv
// Fast-domain tree: USB halving branch and system divide-by-3 plus postscaler.
module clkbr_fast #(
    parameter int USB_DIV    = clkbr_pkg::USB_RATIO,
    parameter int SYS_DIV    = clkbr_pkg::SYS_RATIO,
    parameter int POST_SEL_W = clkbr_pkg::POST_SEL_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  usb_on,
    input  logic [POST_SEL_W-1:0] sys_sel,
    output logic                  usb_stb,
    output logic                  usb_clk,
    output logic                  sys_stb
);
    localparam int USB_W      = $clog2(USB_DIV);
    localparam int SYS_W      = $clog2(SYS_DIV);
    localparam int POST_CNT_W = (2 ** POST_SEL_W) - 1;

    logic                  stb3;
    logic [POST_CNT_W-1:0] post_lim_d;

    always_comb begin
        post_lim_d = (POST_CNT_W'(1) << sys_sel) - POST_CNT_W'(1);
    end

    clkbr_div #(.CNT_W(USB_W)) u_usb_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (~usb_on),
        .ce     (1'b1),
        .lim_in (USB_W'(USB_DIV - 1)),
        .stb    (usb_stb)
    );

    if (USB_DIV % 2 == 0) begin : g_even
        clkbr_half #(.DIV(USB_DIV)) u_half (
            .clk     (clk),
            .rst     (rst),
            .clr     (~usb_on),
            .clk_out (usb_clk)
        );
    end else begin : g_odd
        assign usb_clk = 1'b0;
    end

    clkbr_div #(.CNT_W(SYS_W)) u_sys_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (1'b0),
        .ce     (1'b1),
        .lim_in (SYS_W'(SYS_DIV - 1)),
        .stb    (stb3)
    );

    clkbr_div #(.CNT_W(POST_CNT_W)) u_post_div (
        .clk    (clk),
        .rst    (rst),
        .clr    (1'b0),
        .ce     (stb3),
        .lim_in (post_lim_d),
        .stb    (sys_stb)
    );
endmodule

// File: rtl/clk_branch_gen.sv
module clk_branch_gen #(
    parameter int PRE_SEL_W  = clkbr_pkg::PRE_SEL_W,
    parameter int PRE_CNT_W  = clkbr_pkg::PRE_CNT_W,
    parameter int POST_SEL_W = clkbr_pkg::POST_SEL_W,
    parameter int USB_DIV    = clkbr_pkg::USB_RATIO,
    parameter int SYS_DIV    = clkbr_pkg::SYS_RATIO
) (
    input  logic                  osc_clk,
    input  logic                  osc_rst,
    input  logic [PRE_SEL_W-1:0]  pre_sel,
    output logic                  ref_stb,
    input  logic                  fast_clk,
    input  logic                  fast_rst,
    input  logic                  usb_on,
    input  logic [POST_SEL_W-1:0] sys_sel,
    output logic                  usb_stb,
    output logic                  usb_clk,
    output logic                  sys_stb
);
    clkbr_pre #(.SEL_W(PRE_SEL_W), .CNT_W(PRE_CNT_W)) u_pre (
        .clk (osc_clk),
        .rst (osc_rst),
        .sel (pre_sel),
        .stb (ref_stb)
    );

    clkbr_fast #(
        .USB_DIV    (USB_DIV),
        .SYS_DIV    (SYS_DIV),
        .POST_SEL_W (POST_SEL_W)
    ) u_fast (
        .clk     (fast_clk),
        .rst     (fast_rst),
        .usb_on  (usb_on),
        .sys_sel (sys_sel),
        .usb_stb (usb_stb),
        .usb_clk (usb_clk),
        .sys_stb (sys_stb)
    );
endmodule

// File: rtl/clk_branch_gen_chk.sv
module clk_branch_gen_chk (
    input logic fast_clk,
    input logic fast_rst,
    input logic usb_on,
    input logic usb_stb,
    input logic usb_clk,
    input logic sys_stb
);
    logic live_q;

    always_ff @(posedge fast_clk) begin
        live_q <= ~fast_rst;
    end

    // R6: disabled branch is quiet one edge later
    p_usb_off_quiet_r6: assert property (@(posedge fast_clk) disable iff (fast_rst)
        !usb_on |=> (!usb_stb && !usb_clk));

    // R5: divided clock toggles every edge while enabled
    p_usb_clk_toggle_r5: assert property (@(posedge fast_clk) disable iff (fast_rst)
        (live_q && $past(usb_on)) |-> (usb_clk != $past(usb_clk)));

    // R5: strobe only in the low phase of the divided clock
    p_usb_stb_phase_r5: assert property (@(posedge fast_clk) disable iff (fast_rst)
        usb_stb |-> !usb_clk);

    // R5: strobe is one cycle wide
    p_usb_stb_single_r5: assert property (@(posedge fast_clk) disable iff (fast_rst)
        usb_stb |=> !usb_stb);

    // R7: system strobe is one cycle wide
    p_sys_stb_single_r7: assert property (@(posedge fast_clk) disable iff (fast_rst)
        sys_stb |=> !sys_stb);
endmodule

bind clk_branch_gen clk_branch_gen_chk u_chk (
    .fast_clk (fast_clk),
    .fast_rst (fast_rst),
    .usb_on   (usb_on),
    .usb_stb  (usb_stb),
    .usb_clk  (usb_clk),
    .sys_stb  (sys_stb)
);

// File: tb/tb_clk_branch_gen.sv
module tb_clk_branch_gen;
    logic       osc_clk = 1'b0;
    logic       fast_clk = 1'b0;
    logic       osc_rst = 1'b1;
    logic       fast_rst = 1'b1;
    logic [2:0] pre_sel = 3'd0;
    logic [1:0] sys_sel = 2'd0;
    logic       usb_on = 1'b1;
    logic       ref_stb, usb_stb, usb_clk, sys_stb;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 osc_clk = ~osc_clk;
    always #2 fast_clk = ~fast_clk;

    clk_branch_gen dut (
        .osc_clk  (osc_clk),
        .osc_rst  (osc_rst),
        .pre_sel  (pre_sel),
        .ref_stb  (ref_stb),
        .fast_clk (fast_clk),
        .fast_rst (fast_rst),
        .usb_on   (usb_on),
        .sys_sel  (sys_sel),
        .usb_stb  (usb_stb),
        .usb_clk  (usb_clk),
        .sys_stb  (sys_stb)
    );

    // {pre_sel, sys_sel, prescale ratio, system period}
    localparam logic [20:0] VEC [8] = '{
        {3'd0, 2'd0, 8'd1,  8'd3},
        {3'd1, 2'd1, 8'd2,  8'd6},
        {3'd2, 2'd2, 8'd3,  8'd12},
        {3'd3, 2'd3, 8'd4,  8'd24},
        {3'd4, 2'd0, 8'd5,  8'd3},
        {3'd5, 2'd1, 8'd6,  8'd6},
        {3'd6, 2'd2, 8'd10, 8'd12},
        {3'd7, 2'd3, 8'd12, 8'd24}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_osc(output int first, output int cnt);
        first = 0;
        cnt = 0;
        for (int e = 1; e <= 200; e++) begin
            @(posedge osc_clk);
            @(negedge osc_clk);
            if (ref_stb) begin
                if (first == 0) first = e;
                else if (e <= first + 120) cnt++;
            end
        end
    endtask

    task automatic run_fast(output int f_sys, output int c_sys,
                            output int f_usb, output int c_usb);
        f_sys = 0; c_sys = 0; f_usb = 0; c_usb = 0;
        for (int e = 1; e <= 300; e++) begin
            @(posedge fast_clk);
            @(negedge fast_clk);
            if (sys_stb) begin
                if (f_sys == 0) f_sys = e;
                else if (e <= f_sys + 240) c_sys++;
            end
            if (usb_stb) begin
                if (f_usb == 0) f_usb = e;
                else if (e <= f_usb + 240) c_usb++;
            end
        end
    endtask

    task automatic gap_ref(output int g);
        g = 0;
        for (int e = 1; e <= 100; e++) begin
            @(posedge osc_clk);
            @(negedge osc_clk);
            if (ref_stb && g == 0) g = e;
            if (g != 0) break;
        end
    endtask

    task automatic gap_sys(output int g);
        g = 0;
        for (int e = 1; e <= 100; e++) begin
            @(posedge fast_clk);
            @(negedge fast_clk);
            if (sys_stb && g == 0) g = e;
            if (g != 0) break;
        end
    endtask

    task automatic reset_both();
        @(negedge osc_clk) osc_rst = 1'b1;
        @(negedge fast_clk) fast_rst = 1'b1;
        repeat (3) @(negedge osc_clk);
    endtask

    initial begin
        int f, c, fs, cs, fu, cu, g;
        int n, p;

        // reset state, R3 and R9
        usb_on = 1'b1;
        repeat (4) @(negedge osc_clk);
        chk("R3 ref_stb in reset", int'(ref_stb), 0);
        @(negedge fast_clk);
        chk("R9 sys_stb in reset", int'(sys_stb), 0);
        chk("R9 usb_stb in reset", int'(usb_stb), 0);
        chk("R9 usb_clk in reset", int'(usb_clk), 0);

        // table walk: R1 R2 R3 R5 R7 R9
        foreach (VEC[i]) begin
            pre_sel = VEC[i][20:18];
            sys_sel = VEC[i][17:16];
            n = int'(VEC[i][15:8]);
            p = int'(VEC[i][7:0]);
            reset_both();
            @(negedge osc_clk) osc_rst = 1'b0;
            run_osc(f, c);
            chk($sformatf("R3 first ref_stb code %0d", i), f, n);
            chk($sformatf("R1 R2 ref_stb count code %0d", i), c, 120 / n);
            @(negedge fast_clk) fast_rst = 1'b0;
            run_fast(fs, cs, fu, cu);
            chk($sformatf("R9 first sys_stb vec %0d", i), fs, p + 1);
            chk($sformatf("R7 sys_stb count vec %0d", i), cs, 240 / p);
            chk($sformatf("R5 first usb_stb vec %0d", i), fu, 2);
            chk($sformatf("R5 usb_stb count vec %0d", i), cu, 120);
        end

        // R4: prescaler code change deferred to next wrap
        pre_sel = 3'd3;
        reset_both();
        @(negedge osc_clk) osc_rst = 1'b0;
        gap_ref(g);
        chk("R3 first ref_stb ratio 4", g, 4);
        pre_sel = 3'd7;
        gap_ref(g);
        chk("R4 period in progress keeps old ratio", g, 4);
        gap_ref(g);
        chk("R4 new ratio after wrap", g, 12);

        // R8: postscaler code change deferred to next wrap
        sys_sel = 2'd3;
        reset_both();
        @(negedge fast_clk) fast_rst = 1'b0;
        gap_sys(g);
        chk("R9 first sys_stb postscale 8", g, 25);
        sys_sel = 2'd0;
        gap_sys(g);
        chk("R8 period in progress keeps old ratio", g, 24);
        gap_sys(g);
        chk("R8 new ratio after wrap", g, 3);
        gap_sys(g);
        chk("R7 steady divide by 3", g, 3);

        // R6: USB enable off and back on
        @(negedge fast_clk) usb_on = 1'b0;
        @(negedge fast_clk);
        chk("R6 usb_stb low after disable", int'(usb_stb), 0);
        chk("R6 usb_clk low after disable", int'(usb_clk), 0);
        c = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge fast_clk);
            c += int'(usb_stb) + int'(usb_clk);
        end
        chk("R6 branch stays quiet while disabled", c, 0);
        usb_on = 1'b1;
        @(negedge fast_clk);
        chk("R6 usb_clk high after first edge", int'(usb_clk), 1);
        chk("R6 usb_stb low after first edge", int'(usb_stb), 0);
        @(negedge fast_clk);
        chk("R6 usb_stb after second edge", int'(usb_stb), 1);
        chk("R5 usb_clk low with strobe", int'(usb_clk), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int w = 0; w < 60000; w++) @(posedge osc_clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule